// File: doc/BRIEF.md
# Four-Accumulator Pipelined Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a signal-processing capable processor core. Each issued operation carries two 32-bit source words. The unit takes either the full words or a chosen 16-bit half of each. It reads the operands as signed integers, unsigned integers or signed Q-format fractions and forms their product. It then adds the product to, or subtracts it from, one of four 48-bit accumulators. Per-operation bits select saturation and fractional rounding. Each accumulator has a sticky overflow flag.

Operations enter through a valid/ready issue port, at a rate of up to one per cycle. They pass through a fixed four-stage pipeline: operand preparation, multiplication, product alignment, and accumulation. Accumulation is done only in the last stage, against the live register contents. An operation that directly follows another on the same accumulator therefore sees the earlier result without stalling. A load port writes an accumulator with a given value. The load travels down the same pipeline, so it takes effect in order with operations already in flight. A combinational read port returns any accumulator.

Top module: `mac_quad_unit`

## Requirements
- R1: After reset all four accumulators read zero, all overflow flags are clear, and op_ready is high.
- R2: An operation accepted at clock edge k (op_valid and op_ready high) updates its accumulator at edge k+3, where it is visible on rd_data. One operation can be accepted per cycle.
- R3: With op_wide=1 each operand is the whole 32-bit input. With op_wide=0 each operand is bits [31:16] of its input when its half-select bit (op_hi_a, op_hi_b) is 1, and bits [15:0] when it is 0.
- R4: op_mode encodes the operand format: 0 is signed integer, 1 is unsigned integer (zero-extended), 2 is signed fractional, and 3 behaves as signed integer. Integer products are accumulated unscaled, starting at bit 0.
- R5: In fractional mode the accumulator is Q47 and the product is first doubled. For 32-bit operands the doubled product is shifted right arithmetically by 16. For 16-bit operands it is shifted left by 16.
- R6: op_rnd=1 adds 2^15 to the doubled 32-bit fractional product before the 16-bit right shift. In every other mode op_rnd has no effect.
- R7: op_sub=0 adds the product to the selected accumulator. op_sub=1 subtracts it.
- R8: A result outside the 48-bit signed range clamps to 0x7FFF_FFFF_FFFF or 0x8000_0000_0000 when op_sat=1. When op_sat=0 it keeps its low 48 bits (wraps).
- R9: ovf_flags[i] is set by any out-of-range result on accumulator i, whether op_sat is 0 or 1. It stays set until accumulator i is loaded.
- R10: Back-to-back operations on the same accumulator each accumulate onto the result of the one before, with no idle cycles.
- R11: A load request has priority over an issue request in the same cycle: op_ready is low while ld_valid is high. The load passes through the same four stages as an operation. It writes ld_data into accumulator ld_acc and clears that accumulator's flag, in order with operations issued before and after it.
- R12: Accumulators not selected by a retiring operation or load keep their value.
- R13: rd_data combinationally shows the accumulator selected by rd_acc, and ovf_flags shows all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue request |
| op_ready | output | 1 | Issue accepted this cycle when high with op_valid |
| op_a | input | 32 | First source word |
| op_b | input | 32 | Second source word |
| op_acc | input | 2 | Target accumulator |
| op_mode | input | 2 | Operand format (0 signed, 1 unsigned, 2 fractional) |
| op_wide | input | 1 | 1: 32-bit operands, 0: 16-bit halves |
| op_hi_a | input | 1 | Upper half of op_a when narrow |
| op_hi_b | input | 1 | Upper half of op_b when narrow |
| op_sub | input | 1 | Subtract product instead of adding |
| op_sat | input | 1 | Saturate on overflow |
| op_rnd | input | 1 | Round 32-bit fractional product |
| ld_valid | input | 1 | Accumulator load request |
| ld_acc | input | 2 | Accumulator to load |
| ld_data | input | 48 | Load value |
| rd_acc | input | 2 | Accumulator to read |
| rd_data | output | 48 | Selected accumulator value |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
The bench covers several error-prone cases:
- The minus-one times minus-one fractional product lands exactly one step above the Q47 maximum. An alignment that loses the top bit would return a small or negative number instead of clamping.
- Rounding is checked on a product whose discarded half is exactly one half. A missing or misplaced bias shows up as a result that is off by one.
- Narrow unsigned operands with their top bit set are checked. A design that sign-extends them would accumulate a negative product.
- Same-accumulator bursts with no gaps are checked. A design that read the accumulator early would drop updates.
- A load is interleaved with operations on the same accumulator, and a load collides with an issue request. A design that bypassed the pipeline on loads would be overwritten by an older operation or would apply the load late.

// File: rtl/mac_quad_pkg.sv
package mac_quad_pkg;
  localparam int OP_W       = 32;
  localparam int HALF_W     = OP_W / 2;
  localparam int ACC_W      = 48;
  localparam int ACC_SEL_W  = 2;
  localparam int N_ACC      = 1 << ACC_SEL_W;
  localparam int PROD_W     = 2 * OP_W + 2;
  localparam int SUM_W      = PROD_W + 2;
  localparam int FRAC_DROP  = 2 * OP_W - ACC_W;
  localparam int HALF_SHIFT = ACC_W - 2 * HALF_W;

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    MODE_SINT = 2'd0,
    MODE_UINT = 2'd1,
    MODE_FRAC = 2'd2,
    MODE_RSV  = 2'd3
  } mac_mode_e;

  typedef struct packed {
    logic                 vld;
    logic                 ld;
    logic [ACC_SEL_W-1:0] sel;
    logic                 sub;
    logic                 sat;
    logic                 frac;
    logic                 wide;
    logic                 rnd;
    logic [ACC_W-1:0]     ld_val;
  } mac_ctl_t;

  typedef struct packed {
    logic             ovf;
    logic [ACC_W-1:0] val;
  } acc_step_t;

  // Choose full word or a half, then extend by the operand format.
  function automatic logic signed [OP_W:0] pick_operand(
    input logic [OP_W-1:0] raw, input logic wide, input logic hi, input mac_mode_e mode);
    logic [HALF_W-1:0] h;
    logic              fill;
    h = hi ? raw[OP_W-1:HALF_W] : raw[HALF_W-1:0];
    if (wide) begin
      fill = (mode != MODE_UINT) & raw[OP_W-1];
      return {fill, raw};
    end
    fill = (mode != MODE_UINT) & h[HALF_W-1];
    return {{(OP_W-HALF_W+1){fill}}, h};
  endfunction

  function automatic logic signed [PROD_W-1:0] mul_full(
    input logic signed [OP_W:0] a, input logic signed [OP_W:0] b);
    logic signed [PROD_W-1:0] ea, eb;
    ea = {{(PROD_W-OP_W-1){a[OP_W]}}, a};
    eb = {{(PROD_W-OP_W-1){b[OP_W]}}, b};
    return ea * eb;
  endfunction

  // Place a product on the accumulator's binary point.
  function automatic logic signed [SUM_W-1:0] align_product(
    input logic signed [PROD_W-1:0] p, input logic frac, input logic wide, input logic rnd);
    logic signed [SUM_W-1:0] x;
    x = {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    if (frac) begin
      x = x <<< 1;
      if (wide) begin
        if (rnd) x = x + $signed({{(SUM_W-FRAC_DROP){1'b0}}, 1'b1, {(FRAC_DROP-1){1'b0}}});
        x = x >>> FRAC_DROP;
      end else begin
        x = x <<< HALF_SHIFT;
      end
    end
    return x;
  endfunction

  function automatic acc_step_t acc_step(
    input logic [ACC_W-1:0] acc, input logic signed [SUM_W-1:0] addend,
    input logic sub, input logic sat);
    logic signed [SUM_W-1:0] base, s, hi_lim, lo_lim;
    acc_step_t r;
    base   = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
    hi_lim = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    lo_lim = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
    s      = sub ? base - addend : base + addend;
    r.ovf  = (s > hi_lim) || (s < lo_lim);
    if (r.ovf && sat) r.val = s[SUM_W-1] ? ACC_MIN : ACC_MAX;
    else              r.val = s[ACC_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/mac_issue_stage.sv
module mac_issue_stage
  import mac_quad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [OP_W-1:0]      op_a,
  input  logic [OP_W-1:0]      op_b,
  input  logic [ACC_SEL_W-1:0] op_acc,
  input  logic [1:0]           op_mode,
  input  logic                 op_wide,
  input  logic                 op_hi_a,
  input  logic                 op_hi_b,
  input  logic                 op_sub,
  input  logic                 op_sat,
  input  logic                 op_rnd,
  input  logic                 ld_valid,
  input  logic [ACC_SEL_W-1:0] ld_acc,
  input  logic [ACC_W-1:0]     ld_data,
  output logic                 take_op,
  output logic                 take_ld,
  output mac_ctl_t             s1_ctl,
  output logic signed [OP_W:0] s1_a,
  output logic signed [OP_W:0] s1_b
);
  mac_mode_e mode;
  mac_ctl_t  slot;

  always_comb begin
    mode    = mac_mode_e'(op_mode);
    take_ld = ld_valid;
    take_op = op_valid && !ld_valid;
    slot.vld    = take_ld || take_op;
    slot.ld     = take_ld;
    slot.sel    = take_ld ? ld_acc : op_acc;
    slot.sub    = op_sub;
    slot.sat    = op_sat;
    slot.frac   = (mode == MODE_FRAC);
    slot.wide   = op_wide;
    slot.rnd    = op_rnd;
    slot.ld_val = ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl <= '0;
      s1_a   <= '0;
      s1_b   <= '0;
    end else begin
      s1_ctl <= slot;
      if (take_op) begin
        s1_a <= pick_operand(op_a, op_wide, op_hi_a, mode);
        s1_b <= pick_operand(op_b, op_wide, op_hi_b, mode);
      end
    end
  end
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import mac_quad_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  mac_ctl_t                 s1_ctl,
  input  logic signed [OP_W:0]     s1_a,
  input  logic signed [OP_W:0]     s1_b,
  output mac_ctl_t                 s2_ctl,
  output logic signed [PROD_W-1:0] s2_prod
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_ctl  <= '0;
      s2_prod <= '0;
    end else begin
      s2_ctl <= s1_ctl;
      if (s1_ctl.vld && !s1_ctl.ld) s2_prod <= mul_full(s1_a, s1_b);
    end
  end
endmodule

// File: rtl/mac_align_stage.sv
module mac_align_stage
  import mac_quad_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  mac_ctl_t                 s2_ctl,
  input  logic signed [PROD_W-1:0] s2_prod,
  output mac_ctl_t                 s3_ctl,
  output logic signed [SUM_W-1:0]  s3_add
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_ctl <= '0;
      s3_add <= '0;
    end else begin
      s3_ctl <= s2_ctl;
      if (s2_ctl.vld && !s2_ctl.ld)
        s3_add <= align_product(s2_prod, s2_ctl.frac, s2_ctl.wide, s2_ctl.rnd);
    end
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
  import mac_quad_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  mac_ctl_t                s3_ctl,
  input  logic signed [SUM_W-1:0] s3_add,
  input  logic [ACC_SEL_W-1:0]    rd_acc,
  output logic [ACC_W-1:0]        rd_data,
  output logic [N_ACC-1:0]        ovf_flags
);
  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [N_ACC-1:0] flag_q;
  logic [N_ACC-1:0] acc_we;
  logic [N_ACC-1:0] ld_hit;
  acc_step_t        step;
  logic             wr_ovf;
  logic             sat_hit;

  always_comb begin
    step    = acc_step(acc_q[s3_ctl.sel], s3_add, s3_ctl.sub, s3_ctl.sat);
    wr_ovf  = s3_ctl.vld && !s3_ctl.ld && step.ovf;
    sat_hit = wr_ovf && s3_ctl.sat;
  end

  for (genvar i = 0; i < N_ACC; i++) begin : g_dec
    assign acc_we[i] = s3_ctl.vld && (s3_ctl.sel == ACC_SEL_W'(i));
    assign ld_hit[i] = acc_we[i] && s3_ctl.ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
      flag_q <= '0;
    end else begin
      for (int i = 0; i < N_ACC; i++) begin
        if (acc_we[i]) acc_q[i] <= s3_ctl.ld ? s3_ctl.ld_val : step.val;
        if (ld_hit[i])                     flag_q[i] <= 1'b0;
        else if (acc_we[i] && step.ovf)    flag_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data   = acc_q[rd_acc];
  assign ovf_flags = flag_q;

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> (acc_q[$past(s3_ctl.sel)] == ACC_MAX || acc_q[$past(s3_ctl.sel)] == ACC_MIN)); // R8

  for (genvar i = 0; i < N_ACC; i++) begin : g_chk
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !ld_hit[i]) |=> flag_q[i]); // R9
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hit[i] |=> (!flag_q[i] && acc_q[i] == $past(s3_ctl.ld_val))); // R11
    AST_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_we[i] |=> ($stable(acc_q[i]) && $stable(flag_q[i]))); // R12
  end
endmodule

// File: rtl/mac_quad_unit.sv
module mac_quad_unit
  import mac_quad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [OP_W-1:0]      op_a,
  input  logic [OP_W-1:0]      op_b,
  input  logic [ACC_SEL_W-1:0] op_acc,
  input  logic [1:0]           op_mode,
  input  logic                 op_wide,
  input  logic                 op_hi_a,
  input  logic                 op_hi_b,
  input  logic                 op_sub,
  input  logic                 op_sat,
  input  logic                 op_rnd,
  input  logic                 ld_valid,
  input  logic [ACC_SEL_W-1:0] ld_acc,
  input  logic [ACC_W-1:0]     ld_data,
  input  logic [ACC_SEL_W-1:0] rd_acc,
  output logic [ACC_W-1:0]     rd_data,
  output logic [N_ACC-1:0]     ovf_flags
);
  logic                     take_op, take_ld;
  mac_ctl_t                 s1_ctl, s2_ctl, s3_ctl;
  logic signed [OP_W:0]     s1_a, s1_b;
  logic signed [PROD_W-1:0] s2_prod;
  logic signed [SUM_W-1:0]  s3_add;

  assign op_ready = !ld_valid;

  mac_issue_stage i_issue (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .op_acc(op_acc), .op_mode(op_mode), .op_wide(op_wide), .op_hi_a(op_hi_a),
    .op_hi_b(op_hi_b), .op_sub(op_sub), .op_sat(op_sat), .op_rnd(op_rnd),
    .ld_valid(ld_valid), .ld_acc(ld_acc), .ld_data(ld_data),
    .take_op(take_op), .take_ld(take_ld), .s1_ctl(s1_ctl), .s1_a(s1_a), .s1_b(s1_b)
  );

  mac_mult_stage i_mult (
    .clk(clk), .rst_n(rst_n), .s1_ctl(s1_ctl), .s1_a(s1_a), .s1_b(s1_b),
    .s2_ctl(s2_ctl), .s2_prod(s2_prod)
  );

  mac_align_stage i_align (
    .clk(clk), .rst_n(rst_n), .s2_ctl(s2_ctl), .s2_prod(s2_prod),
    .s3_ctl(s3_ctl), .s3_add(s3_add)
  );

  mac_acc_bank i_bank (
    .clk(clk), .rst_n(rst_n), .s3_ctl(s3_ctl), .s3_add(s3_add),
    .rd_acc(rd_acc), .rd_data(rd_data), .ovf_flags(ovf_flags)
  );

  AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |-> ##3 (s3_ctl.vld && !s3_ctl.ld && s3_ctl.sel == $past(op_acc, 3))); // R2
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ld_valid) |-> ##3 (s3_ctl.vld && s3_ctl.ld)); // R11
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_op, take_ld})); // R11
endmodule

// File: tb/test_mac_quad_unit.sv
`timescale 1ns/100ps
module test_mac_quad_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  op_acc = '0, op_mode = '0;
  logic        op_wide = 1'b0, op_hi_a = 1'b0, op_hi_b = 1'b0;
  logic        op_sub = 1'b0, op_sat = 1'b0, op_rnd = 1'b0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_acc = '0;
  logic [47:0] ld_data = '0;
  logic [1:0]  rd_acc = '0;
  logic [47:0] rd_data;
  logic [3:0]  ovf_flags;

  always #2 clk = ~clk;

  mac_quad_unit i_mac_quad_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .op_acc(op_acc), .op_mode(op_mode),
    .op_wide(op_wide), .op_hi_a(op_hi_a), .op_hi_b(op_hi_b), .op_sub(op_sub),
    .op_sat(op_sat), .op_rnd(op_rnd), .ld_valid(ld_valid), .ld_acc(ld_acc),
    .ld_data(ld_data), .rd_acc(rd_acc), .rd_data(rd_data), .ovf_flags(ovf_flags)
  );

  typedef struct {
    int          due;
    logic [1:0]  sel;
    logic [47:0] val;
    logic [3:0]  flg;
    string       req;
  } sb_item_t;

  sb_item_t    sbq[$];
  sb_item_t    mon_it;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [47:0] m_acc [4];
  logic [3:0]  m_flag;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Operand as the requirements define it, as a wide signed number.
  function automatic logic signed [127:0] ref_operand(input logic [31:0] v, input logic wide,
                                                     input logic hi, input logic [1:0] mode);
    logic [31:0] f;
    f = wide ? v : (hi ? {16'h0, v[31:16]} : {16'h0, v[15:0]});
    if (mode == 2'd1) return {96'h0, f};
    if (!wide) return $signed({{112{f[15]}}, f[15:0]});
    return $signed({{96{f[31]}}, f});
  endfunction

  task automatic model_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] sel,
                          input logic [1:0] mode, input logic wide, input logic ha, input logic hb,
                          input logic sub, input logic sat, input logic rnd);
    logic signed [127:0] p, s, top, bot;
    p = ref_operand(a, wide, ha, mode) * ref_operand(b, wide, hb, mode);
    if (mode == 2'd2) begin
      p = p * 2;
      if (wide) begin
        if (rnd) p = p + 128'sd32768;
        p = p >>> 16;
      end else begin
        p = p * 65536;
      end
    end
    s   = $signed({{80{m_acc[sel][47]}}, m_acc[sel]});
    s   = sub ? s - p : s + p;
    top = (128'sd1 <<< 47) - 128'sd1;
    bot = -(128'sd1 <<< 47);
    if (s > top || s < bot) begin
      m_flag[sel] = 1'b1;
      if (sat) m_acc[sel] = (s < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
      else     m_acc[sel] = s[47:0];
    end else begin
      m_acc[sel] = s[47:0];
    end
  endtask

  task automatic push(input logic [1:0] sel, input int delay, input string req);
    sb_item_t it;
    it.due = cyc + delay; it.sel = sel; it.val = m_acc[sel]; it.flg = m_flag; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic set_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] sel,
                        input logic [1:0] mode, input logic wide, input logic ha, input logic hb,
                        input logic sub, input logic sat, input logic rnd);
    op_valid = 1'b1; op_a = a; op_b = b; op_acc = sel; op_mode = mode; op_wide = wide;
    op_hi_a = ha; op_hi_b = hb; op_sub = sub; op_sat = sat; op_rnd = rnd;
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] sel,
                       input logic [1:0] mode, input logic wide, input logic ha, input logic hb,
                       input logic sub, input logic sat, input logic rnd, input string req);
    @(negedge clk);
    ld_valid = 1'b0;
    set_op(a, b, sel, mode, wide, ha, hb, sub, sat, rnd);
    model_op(a, b, sel, mode, wide, ha, hb, sub, sat, rnd);
    push(sel, 4, req);
  endtask

  task automatic do_load(input logic [1:0] sel, input logic [47:0] val, input string req);
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b1; ld_acc = sel; ld_data = val;
    m_acc[sel] = val; m_flag[sel] = 1'b0;
    push(sel, 4, req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0; ld_valid = 1'b0;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 50 && sbq.size() > 0; k++) idle(1);
    check(sbq.size() == 0, "R2", "scoreboard drained", 64'(sbq.size()), 64'd0);
    sbq.delete();
  endtask

  // Monitor: pop each expected retirement in its cycle and compare at the ports.
  always begin
    @(negedge clk);
    #0.4;
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      mon_it = sbq.pop_front();
      rd_acc = mon_it.sel;
      #0.4;
      check(rd_data === mon_it.val, mon_it.req, "accumulator", 64'(rd_data), 64'(mon_it.val));
      check(ovf_flags === mon_it.flg, mon_it.req, "flags", 64'(ovf_flags), 64'(mon_it.flg));
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_flag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_acc = 2'(i);
      #0.4;
      check(rd_data === 48'h0, "R1", "acc after reset", 64'(rd_data), 64'h0);
    end
    check(ovf_flags === 4'h0, "R1", "flags after reset", 64'(ovf_flags), 64'h0);
    check(op_ready === 1'b1, "R1", "ready after reset", 64'(op_ready), 64'h1);

    // R4: signed and unsigned 32-bit integers
    issue(32'd7, 32'hFFFF_FFFD, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, "R4");
    issue(32'hFFFF_FFFD, 32'd2, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, "R4");
    issue(32'd5, 32'hFFFF_FFFF, 2'd0, 2'd3, 1, 0, 0, 0, 0, 0, "R4");
    // R3: half selection, signed and unsigned narrow
    issue(32'h0003_FFFE, 32'h0005_0002, 2'd2, 2'd0, 0, 1, 0, 0, 0, 0, "R3");
    issue(32'h0003_FFFE, 32'h0005_0002, 2'd2, 2'd0, 0, 0, 1, 0, 0, 0, "R3");
    issue(32'h0003_FFFE, 32'h0005_0002, 2'd3, 2'd1, 0, 0, 1, 0, 0, 0, "R3");
    drain();

    // R5: fractional alignment for both widths
    do_load(2'd0, 48'h0, "R11");
    issue(32'h4000_0000, 32'h0000_4000, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0, "R5");
    issue(32'h4000_0000, 32'h4000_0000, 2'd0, 2'd2, 1, 0, 0, 0, 0, 0, "R5");
    issue(32'h0000_C000, 32'h4000_0000, 2'd0, 2'd2, 0, 0, 1, 0, 0, 0, "R5");
    // R6: rounding at exactly one half, and no effect in integer mode
    do_load(2'd1, 48'h0, "R11");
    issue(32'h0000_0001, 32'h0000_4000, 2'd1, 2'd2, 1, 0, 0, 0, 0, 0, "R6");
    issue(32'h0000_0001, 32'h0000_4000, 2'd1, 2'd2, 1, 0, 0, 0, 0, 1, "R6");
    issue(32'h0000_0003, 32'h0000_0004, 2'd1, 2'd0, 1, 0, 0, 0, 0, 1, "R6");
    // R7: subtract
    issue(32'd100, 32'd3, 2'd1, 2'd0, 1, 0, 0, 1, 0, 0, "R7");
    drain();

    // R8 R9: minus one squared in fractional, saturating then wrapping
    do_load(2'd3, 48'h0, "R11");
    issue(32'h8000_0000, 32'h8000_0000, 2'd3, 2'd2, 1, 0, 0, 0, 1, 0, "R8");
    issue(32'd1, 32'd1, 2'd3, 2'd0, 1, 0, 0, 1, 0, 0, "R9");
    do_load(2'd2, 48'h0, "R11");
    issue(32'h8000_0000, 32'h8000_0000, 2'd2, 2'd2, 1, 0, 0, 0, 0, 0, "R8");
    do_load(2'd0, 48'h8000_0000_0001, "R11");
    issue(32'd2, 32'd1, 2'd0, 2'd0, 1, 0, 0, 1, 1, 0, "R8");
    do_load(2'd1, 48'h8000_0000_0001, "R11");
    issue(32'd2, 32'd1, 2'd1, 2'd0, 1, 0, 0, 1, 0, 0, "R8");
    drain();

    // R10: gapless burst on one accumulator
    for (int k = 0; k < 6; k++)
      issue(32'(k + 3), 32'(1000 - k), 2'd2, 2'd0, 1, 0, 0, k[0], 0, 0, "R10");
    // R11: load between in-flight operations on the same accumulator
    issue(32'd9, 32'd9, 2'd1, 2'd0, 1, 0, 0, 0, 0, 0, "R11");
    do_load(2'd1, 48'h0000_1234_5678, "R11");
    issue(32'd2, 32'd3, 2'd1, 2'd0, 1, 0, 0, 0, 0, 0, "R11");
    // R11: load and issue requested together
    @(negedge clk);
    ld_valid = 1'b1; ld_acc = 2'd3; ld_data = 48'h0000_0000_0100;
    set_op(32'd4, 32'd5, 2'd3, 2'd0, 1, 0, 0, 0, 0, 0);
    m_acc[3] = 48'h100; m_flag[3] = 1'b0;
    push(2'd3, 4, "R11");
    #0.4;
    check(op_ready === 1'b0, "R11", "ready with load pending", 64'(op_ready), 64'h0);
    @(negedge clk);
    ld_valid = 1'b0;
    model_op(32'd4, 32'd5, 2'd3, 2'd0, 1, 0, 0, 0, 0, 0);
    push(2'd3, 4, "R11");
    #0.4;
    check(op_ready === 1'b1, "R11", "ready after load", 64'(op_ready), 64'h1);
    drain();

    // R2 R10: mixed burst over all modes and accumulators
    for (int k = 0; k < 160; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ($urandom % 2) a = a >> ($urandom % 32);
      if ($urandom % 2) b = b >> ($urandom % 32);
      issue(a, b, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), "R10");
      if (k % 37 == 36) do_load(2'($urandom), 48'($urandom), "R11");
    end
    drain();

    // R12 R13: every accumulator through the read port
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_acc = 2'(i);
      #0.4;
      check(rd_data === m_acc[i], "R13", "final read", 64'(rd_data), 64'(m_acc[i]));
    end
    check(ovf_flags === m_flag, "R12", "final flags", 64'(ovf_flags), 64'(m_flag));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule